// File: doc/BRIEF.md
# Wired Interrupt Source Gateway

This block sits between a bank of wired interrupt inputs and the delivery logic of one interrupt domain. Sources are numbered from 1. For each source, a three-bit mode chosen by software decides how its wire is read: ignored entirely, cut off from the wire, triggered by a rising or falling edge, or held by a high or low level. The block keeps one pending flag and one enable flag per source and gives both to a delivery unit. The unit reports back which source it has taken through a claim strobe.

Software uses a single-cycle write port and a read port with one cycle of latency. A domain word holds a global enable bit, together with a delivery-mode bit and a byte-order bit that are only stored. Each source has a configuration word holding its mode and a stored delegation flag. Enables are not written as bitmasks. Software writes a source number to a set-enable location or to a clear-enable location. All inputs pass through a two-stage synchronizer before any edge or level is detected.

Top module: `irq_src_gateway`

## Requirements
- R1: After reset every source is inactive (mode 0) with pending and enable clear, the domain word reads 0, and the ready vector is 0.
- R2: The configuration word of source i sits at byte address 4*i (i from 1 to NUM_SRC). A read returns only the mode in bits 2:0 and the delegation flag in bit 10. The domain word at address 0 keeps only bit 8 (global enable), bit 2 (delivery mode) and bit 0 (byte order). Reads return data one cycle after the address is presented. Unaligned addresses and addresses of sources above NUM_SRC read as 0.
- R3: In mode 4 (rising edge), a 0-to-1 change of the synchronized input sets the pending flag. The flag then stays set after the input falls, until the source is claimed.
- R4: In mode 5 (falling edge), a 1-to-0 change of the synchronized input sets the pending flag. The flag stays set until the source is claimed.
- R5: In mode 6 (level high), the pending flag follows the input. In mode 7 (level low), it follows the inverted input.
- R6: A claim strobe carrying source number n clears the pending flag of n on the next clock edge. In a level mode the flag rises again one cycle later while the level is still asserted. A claim that names source 0 changes nothing.
- R7: In mode 1 (detached), the input wire never sets the pending flag, but enable writes still take effect.
- R8: Mode 0 and the unused codes 2 and 3 act as inactive. Pending stays 0, the enable flag is cleared, and set-enable writes to the source are ignored.
- R9: Writing source number n to address 0x1EDC sets the enable of n, and writing it to 0x1FDC clears it. The number 0 and numbers above NUM_SRC are ignored.
- R10: Ready bit i-1 is 1 exactly when source i was pending and enabled while the global enable was set, one clock before. With the global enable clear, the ready vector is 0.
- R11: Any write to the configuration word of a source clears that source's pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DATA_W | Read data, one cycle after rd_addr |
| src_in | input | NUM_SRC | Interrupt wires; bit i-1 belongs to source i |
| claim_valid | input | 1 | Delivery unit has taken a source |
| claim_id | input | ID_W | Number of the source taken |
| pending | output | NUM_SRC | Pending flag per source |
| ready | output | NUM_SRC | Pending, enabled and globally allowed, registered |

## Verification
Every mode is swept across all eight sources with one sequence of input vectors. The vectors contain rising and falling changes, all-high and all-low states, and bits that hold their value. Edge modes show pending accumulating and level modes show it tracking the wire, so a swapped edge polarity or a level treated as an edge shows up as a differing vector. Detached, inactive and the unused codes run through the same sequence and must stay at zero. Separate directed sequences cover claim re-raise against edge hold, out-of-range enable numbers, global gating and readback masking.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;
  localparam logic [2:0] MD_OFF    = 3'd0;
  localparam logic [2:0] MD_DETACH = 3'd1;
  localparam logic [2:0] MD_RISE   = 3'd4;
  localparam logic [2:0] MD_FALL   = 3'd5;
  localparam logic [2:0] MD_HIGH   = 3'd6;
  localparam logic [2:0] MD_LOW    = 3'd7;

  localparam int DLG_BIT   = 10;
  localparam int GIE_BIT   = 8;
  localparam int DMODE_BIT = 2;
  localparam int BORD_BIT  = 0;

  localparam int ADR_DOMAIN = 'h0000;
  localparam int ADR_SETEN  = 'h1EDC;
  localparam int ADR_CLREN  = 'h1FDC;

  function automatic logic mode_is_off(input logic [2:0] m);
    return (m == MD_OFF) || (m == 3'd2) || (m == 3'd3);
  endfunction
endpackage

// File: rtl/irq_gw_sync.sv
module irq_gw_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/irq_gw_slot.sv
module irq_gw_slot
  import irq_gw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [2:0] cfg_mode,
  input  logic       cfg_dlg,
  input  logic       set_en,
  input  logic       clr_en,
  input  logic       claim,
  input  logic       lvl,
  input  logic       prev,
  output logic [2:0] mode_q,
  output logic       dlg_q,
  output logic       pend_q,
  output logic       en_q,
  output logic       off,
  output logic       detached
);
  logic pend_nx;

  assign off      = mode_is_off(mode_q);
  assign detached = (mode_q == MD_DETACH);

  always_comb begin
    unique case (mode_q)
      MD_RISE:   pend_nx = (lvl & ~prev) | (pend_q & ~claim);
      MD_FALL:   pend_nx = (~lvl & prev) | (pend_q & ~claim);
      MD_HIGH:   pend_nx = lvl & ~claim;
      MD_LOW:    pend_nx = ~lvl & ~claim;
      MD_DETACH: pend_nx = pend_q & ~claim;
      default:   pend_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_OFF;
      dlg_q  <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (cfg_we) begin
      mode_q <= cfg_mode;
      dlg_q  <= cfg_dlg;
      pend_q <= 1'b0;
      if (mode_is_off(cfg_mode)) en_q <= 1'b0;
    end else begin
      pend_q <= pend_nx;
      if (off)         en_q <= 1'b0;
      else if (set_en) en_q <= 1'b1;
      else if (clr_en) en_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_src_gateway.sv
module irq_src_gateway
  import irq_gw_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic              claim_valid,
  input  logic [ID_W-1:0]   claim_id,
  output logic [NUM_SRC-1:0] pending,
  output logic [NUM_SRC-1:0] ready
);
  localparam int IDX_W = ADDR_W - 2;

  logic [NUM_SRC-1:0] lvl, prev, en_vec, off_vec, detach_vec, dlg_vec;
  logic [2:0]         mode_arr [NUM_SRC];
  logic [GIE_BIT:0]   dom_q;
  logic               gie;
  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic               wr_algn, rd_algn, wr_set, wr_clr;
  logic [DATA_W-1:0]  rd_nx;

  assign wr_idx  = wr_addr[ADDR_W-1:2];
  assign rd_idx  = rd_addr[ADDR_W-1:2];
  assign wr_algn = (wr_addr[1:0] == 2'b00);
  assign rd_algn = (rd_addr[1:0] == 2'b00);
  assign wr_set  = wr_en && (wr_addr == ADDR_W'(ADR_SETEN));
  assign wr_clr  = wr_en && (wr_addr == ADDR_W'(ADR_CLREN));
  assign gie     = dom_q[GIE_BIT];

  irq_gw_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(src_in), .lvl(lvl), .prev(prev)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    logic cfg_we_i, set_i, clr_i, claim_i;
    assign cfg_we_i = wr_en && wr_algn && (wr_idx == IDX_W'(i + 1));
    assign set_i    = wr_set && (wr_data == DATA_W'(i + 1));
    assign clr_i    = wr_clr && (wr_data == DATA_W'(i + 1));
    assign claim_i  = claim_valid && (claim_id == ID_W'(i + 1));

    irq_gw_slot u_slot (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we_i), .cfg_mode(wr_data[2:0]), .cfg_dlg(wr_data[DLG_BIT]),
      .set_en(set_i), .clr_en(clr_i), .claim(claim_i),
      .lvl(lvl[i]), .prev(prev[i]),
      .mode_q(mode_arr[i]), .dlg_q(dlg_vec[i]), .pend_q(pending[i]),
      .en_q(en_vec[i]), .off(off_vec[i]), .detached(detach_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_q <= '0;
    end else if (wr_en && (wr_addr == ADDR_W'(ADR_DOMAIN))) begin
      dom_q <= '0;
      dom_q[GIE_BIT]   <= wr_data[GIE_BIT];
      dom_q[DMODE_BIT] <= wr_data[DMODE_BIT];
      dom_q[BORD_BIT]  <= wr_data[BORD_BIT];
    end
  end

  always_comb begin
    rd_nx = '0;
    if (rd_addr == ADDR_W'(ADR_DOMAIN)) begin
      rd_nx[GIE_BIT:0] = dom_q;
    end else if (rd_algn) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (rd_idx == IDX_W'(i + 1)) begin
          rd_nx[2:0]     = mode_arr[i];
          rd_nx[DLG_BIT] = dlg_vec[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      ready   <= '0;
    end else begin
      rd_data <= rd_nx;
      ready   <= gie ? (pending & en_vec) : '0;
    end
  end
endmodule

// File: rtl/irq_src_gateway_chk.sv
module irq_src_gateway_chk #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               gie,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic [NUM_SRC-1:0] pending,
  input logic [NUM_SRC-1:0] ready,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] off_vec,
  input logic [NUM_SRC-1:0] detach_vec
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'('h1EDC);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'('h1FDC);
  localparam logic [DATA_W-1:0] N_D   = DATA_W'(NUM_SRC);

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    ((pending & off_vec) == '0) && ((en_vec & off_vec) == '0));

  assert_detach_no_rise_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending & ~$past(pending) & $past(detach_vec)) == '0));

  assert_bad_number_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == A_SET || wr_addr == A_CLR) &&
     (wr_data == '0 || wr_data > N_D)) |=> $stable(en_vec));

  assert_gate_off_R10: assert property (@(posedge clk) disable iff (rst)
    !gie |=> (ready == '0));

  assert_ready_subset_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ready & ~$past(pending)) == '0));
endmodule

bind irq_src_gateway irq_src_gateway_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .gie(gie), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pending(pending), .ready(ready), .en_vec(en_vec),
  .off_vec(off_vec), .detach_vec(detach_vec)
);

// File: tb/irq_src_gateway_tb.sv
module irq_src_gateway_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int AW   = 14;
  localparam int DW   = 32;
  localparam int IW   = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [N-1:0]  src_in = '0;
  logic          claim_valid = 1'b0;
  logic [IW-1:0] claim_id = '0;
  logic [N-1:0]  pending, ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_src_gateway #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_in(src_in),
    .claim_valid(claim_valid), .claim_id(claim_id),
    .pending(pending), .ready(ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic do_claim(input int id);
    @(negedge clk);
    claim_valid = 1'b1; claim_id = IW'(id);
    @(negedge clk);
    claim_valid = 1'b0;
  endtask

  task automatic cfg_all(input logic [2:0] m);
    for (int i = 1; i <= N; i++) reg_wr(4*i, {29'd0, m});
  endtask

  task automatic en_all();
    for (int i = 1; i <= N; i++) reg_wr('h1EDC, i);
  endtask

  function automatic logic [N-1:0] model(input logic [2:0] m, input logic [N-1:0] o,
                                         input logic [N-1:0] nw, input logic [N-1:0] p);
    case (m)
      3'd4: return p | (nw & ~o);
      3'd5: return p | (o & ~nw);
      3'd6: return nw;
      3'd7: return ~nw;
      default: return '0;
    endcase
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd4: return "R3 rise";
      3'd5: return "R4 fall";
      3'd6, 3'd7: return "R5 level";
      3'd1: return "R7 detached";
      default: return "R8 inactive";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    logic [2:0]  modes [8] = '{3'd4, 3'd5, 3'd6, 3'd7, 3'd1, 3'd0, 3'd2, 3'd3};
    logic [N-1:0] pats [5] = '{8'hA5, 8'h5A, 8'hFF, 8'h3C, 8'h00};

    wait_n(4);
    rst = 1'b0;
    wait_n(1);

    // R1 reset state
    check("R1 pending", 32'(pending), 0);
    check("R1 ready", 32'(ready), 0);
    reg_rd(0, rv);   check("R1 domain", rv, 0);
    reg_rd(12, rv);  check("R1 cfg3", rv, 0);

    // R2 readback masking and addressing
    reg_wr(0, 32'hFFFF_FFFF);
    reg_rd(0, rv);   check("R2 domain mask", rv, 32'h105);
    for (int i = 1; i <= N; i++) begin
      logic [2:0] m = (i % 2) ? 3'd5 : 3'd6;
      reg_wr(4*i, 32'hFFFF_F000 | 32'h400 | 32'(m));
      reg_rd(4*i, rv);
      check($sformatf("R2 cfg%0d", i), rv, 32'h400 | 32'(m));
    end
    reg_rd(4*(N+1), rv); check("R2 out of range", rv, 0);
    reg_rd(6, rv);       check("R2 unaligned", rv, 0);

    // Mode sweep: R3 R4 R5 R7 R8 with R10 ready
    foreach (modes[mi]) begin
      logic [2:0] m = modes[mi];
      logic [N-1:0] o, p, en_e;
      src_in = '0;
      wait_n(6);
      cfg_all(m);
      en_all();
      reg_wr(0, 32'h100);
      wait_n(6);
      en_e = ((m == 3'd0) || (m == 3'd2) || (m == 3'd3)) ? '0 : '1;
      o = '0;
      p = model(m, '0, '0, '0);
      check({mode_tag(m), " idle"}, 32'(pending), 32'(p));
      foreach (pats[pi]) begin
        @(negedge clk);
        src_in = pats[pi];
        wait_n(6);
        p = model(m, o, pats[pi], p);
        o = pats[pi];
        check($sformatf("%s pend pat%0d", mode_tag(m), pi), 32'(pending), 32'(p));
        check($sformatf("R10 ready mode%0d pat%0d", m, pi), 32'(ready), 32'(p & en_e));
      end
    end

    // R6 claim: edge holds cleared, level re-raises
    src_in = '0; wait_n(6);
    cfg_all(3'd4); en_all(); reg_wr(0, 32'h100);
    @(negedge clk); src_in = 8'h0F; wait_n(6);
    check("R3 setup", 32'(pending), 32'h0F);
    do_claim(2);
    check("R6 edge claim", 32'(pending), 32'h0D);
    wait_n(5);
    check("R6 edge stays clear", 32'(pending), 32'h0D);
    do_claim(0);
    wait_n(2);
    check("R6 claim zero", 32'(pending), 32'h0D);

    // R11 config write clears pending
    reg_wr(4, 32'd4);
    check("R11 cfg clears", 32'(pending), 32'h0C);

    cfg_all(3'd6); wait_n(4);
    check("R5 level setup", 32'(pending), 32'h0F);
    do_claim(3);
    check("R6 level claim", 32'(pending), 32'h0B);
    wait_n(1);
    check("R6 level re-raise", 32'(pending), 32'h0F);

    // R9 enable by number
    @(negedge clk); src_in = 8'hFF; wait_n(6);
    check("R9 all ready", 32'(ready), 32'hFF);
    reg_wr('h1FDC, 3); wait_n(2);
    check("R9 clear 3", 32'(ready), 32'hFB);
    reg_wr('h1FDC, 0); reg_wr('h1FDC, N+1); wait_n(2);
    check("R9 clear ignored", 32'(ready), 32'hFB);
    reg_wr('h1FDC, 1); reg_wr('h1EDC, 0); reg_wr('h1EDC, N+1); wait_n(2);
    check("R9 set ignored", 32'(ready), 32'hFA);
    reg_wr('h1EDC, 3); wait_n(2);
    check("R9 set 3", 32'(ready), 32'hFE);

    // R10 global gate
    reg_wr(0, 32'h0); wait_n(2);
    check("R10 gate off", 32'(ready), 0);
    check("R10 pending kept", 32'(pending), 32'hFF);
    reg_wr(0, 32'h100); wait_n(2);
    check("R10 gate on", 32'(ready), 32'hFE);

    // R8 set-enable ignored while inactive; R7 enable works while detached
    reg_wr(4*5, 0); reg_wr(4*6, 1);
    reg_wr('h1EDC, 5); reg_wr('h1EDC, 6);
    reg_wr(4*5, 6); reg_wr(4*6, 6); wait_n(4);
    check("R8 enable not taken", 32'(ready[4]), 0);
    check("R7 enable taken", 32'(ready[5]), 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule